// File: doc/BRIEF.md
# Link-side serial request transmitter

This block sits on the link-layer side of a PHY-link interface and sends requests to the PHY over one serial wire, one bit per clock. A command port carries a request kind plus its operands. The block turns each command into a frame that starts with a 1 bit, followed by a 3-bit type code and any operand fields, and ends with a 0 bit. Register read, register write and arbitration-acceleration frames go out as soon as they are accepted. Bus-access requests (fair, priority, immediate, isochronous) are held back until the interface state on the 2-bit control input allows them.

A fair or priority request waits for an idle gap. A receive indication on the control input wipes out such a request, and the block then sends the request again in full after the next idle gap. An immediate request is used to send an acknowledge. It only goes out while a packet is being received. The block then waits for the grant. At the grant it either starts the acknowledge or, if the header CRC of the received packet was flagged bad, drops the grant at once. An isochronous request waits until a cycle start has been seen.

The controller has four states. IDLE accepts a command. PEND waits for the start rule of the request kind. SHIFT drives the frame. WGRANT waits for the grant that follows an immediate request. The transitions are:
- accept: IDLE to PEND.
- launch: PEND to SHIFT.
- drop-on-receive: SHIFT to PEND.
- finish: SHIFT to IDLE.
- await-grant: SHIFT to WGRANT, for an immediate request only.
- grant: WGRANT to IDLE.

Top module: `lreq_tx`

## Requirements
- R1: A register read (cmd_kind 0) sends 9 bits in this order: 1, type 1,0,0, the 4 address bits MSB first, then 0.
- R2: A register write (cmd_kind 1) sends 17 bits in this order: 1, type 1,0,1, the 4 address bits MSB first, the 8 data bits MSB first, then 0.
- R3: An acceleration control (cmd_kind 2) sends 6 bits in this order: 1, type 1,1,0, the enable bit (1 = acceleration on), then 0.
- R4: Access requests send 5 bits: 1, a 3-bit code MSB first, then 0. The codes are fair (cmd_kind 3) 011, priority (4) 010, immediate (5) 000 and isochronous (6) 001. The serial output is 0 whenever no frame is being sent.
- R5: The start bit of a fair or priority request appears only after ctl has been idle (00) at two consecutive clock edges. The request waits for as long as ctl is not idle.
- R6: If ctl shows receive (10) while a fair or priority frame is being shifted, the output returns to 0 on the next clock and busy stays high. The complete frame is sent again once R5 is met.
- R7: An immediate request does not start until ctl shows receive (10).
- R8: After an immediate frame, the block waits for grant (ctl 11). At the grant it pulses ack_start, or it pulses ack_cancel instead if hcrc_err was high at any point since the command was accepted. The two pulses never occur together.
- R9: An isochronous request waits until a cyc_start pulse has been seen. Each such pulse enables one isochronous frame.
- R10: busy rises on the clock after an accepted cmd_valid and stays high until the frame ends, or until the grant for an immediate request. done pulses for one clock as busy falls. cmd_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_kind | input | 3 | Request kind, 0 to 6 |
| cmd_addr | input | 4 | Register address |
| cmd_data | input | 8 | Register write data |
| cmd_accel | input | 1 | Acceleration enable for kind 2 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| ctl | input | 2 | Interface state from PHY: 00 idle, 01 status, 10 receive, 11 grant |
| hcrc_err | input | 1 | Header CRC of the received packet is bad |
| cyc_start | input | 1 | Cycle start message sent or received |
| lreq | output | 1 | Serial request output |
| ack_start | output | 1 | Grant is used for an acknowledge |
| ack_cancel | output | 1 | Grant is released without transmitting |

## Verification
Two things can meet in the same cycle: a receive indication on ctl and the shifting of a fair request that is already under way. The bench raises receive while the second bit of a fair frame is on the wire. It then checks that the line drops to 0 on the next clock, that busy stays high, and that the complete frame is sent again after a fresh idle gap. The scoreboard compares the resent frame bit by bit. A second overlap is checked too: a bad header CRC is flagged during reception and the grant follows. The bench then checks that only the cancel pulse appears.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
    typedef enum logic [2:0] {
        K_READ  = 3'd0,
        K_WRITE = 3'd1,
        K_ACCEL = 3'd2,
        K_FAIR  = 3'd3,
        K_PRI   = 3'd4,
        K_IMM   = 3'd5,
        K_ISO   = 3'd6
    } kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PEND,
        S_SHIFT,
        S_WGRANT
    } st_t;

    localparam logic [1:0] CTL_IDLE  = 2'b00;
    localparam logic [1:0] CTL_RCV   = 2'b10;
    localparam logic [1:0] CTL_GRANT = 2'b11;

    localparam logic [2:0] TC_READ  = 3'b100;
    localparam logic [2:0] TC_WRITE = 3'b101;
    localparam logic [2:0] TC_ACCEL = 3'b110;
    localparam logic [2:0] TC_FAIR  = 3'b011;
    localparam logic [2:0] TC_PRI   = 3'b010;
    localparam logic [2:0] TC_IMM   = 3'b000;
    localparam logic [2:0] TC_ISO   = 3'b001;
endpackage

// File: rtl/lreq_framer.sv
module lreq_framer
    import lreq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 5 + ADDR_W + DATA_W,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  kind_t              kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    input  logic               accel,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len
);
    localparam int LEN_READ   = 5 + ADDR_W;
    localparam int LEN_ACCEL  = 6;
    localparam int LEN_ACCESS = 5;

    always_comb begin
        frame = '0;
        len   = CNT_W'(LEN_ACCESS);
        unique case (kind)
            K_READ: begin
                frame = {1'b1, TC_READ, addr, 1'b0, {DATA_W{1'b0}}};
                len   = CNT_W'(LEN_READ);
            end
            K_WRITE: begin
                frame = {1'b1, TC_WRITE, addr, data, 1'b0};
                len   = CNT_W'(FRAME_W);
            end
            K_ACCEL: begin
                frame = {1'b1, TC_ACCEL, accel, 1'b0, {(ADDR_W+DATA_W-1){1'b0}}};
                len   = CNT_W'(LEN_ACCEL);
            end
            K_FAIR:  frame = {1'b1, TC_FAIR, 1'b0, {(ADDR_W+DATA_W){1'b0}}};
            K_PRI:   frame = {1'b1, TC_PRI,  1'b0, {(ADDR_W+DATA_W){1'b0}}};
            K_IMM:   frame = {1'b1, TC_IMM,  1'b0, {(ADDR_W+DATA_W){1'b0}}};
            K_ISO:   frame = {1'b1, TC_ISO,  1'b0, {(ADDR_W+DATA_W){1'b0}}};
            default: frame = '0;
        endcase
    end
endmodule

// File: rtl/lreq_shifter.sv
module lreq_shifter #(
    parameter int FRAME_W = 17,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               abort,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   len,
    output logic               ser,
    output logic               last
);
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic               act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
            act <= 1'b0;
            ser <= 1'b0;
        end else if (load) begin
            act <= 1'b1;
            ser <= frame[FRAME_W-1];
            sh  <= frame << 1;
            cnt <= len - CNT_W'(1);
        end else if (abort) begin
            act <= 1'b0;
            ser <= 1'b0;
        end else if (act) begin
            if (cnt == '0) begin
                act <= 1'b0;
                ser <= 1'b0;
            end else begin
                ser <= sh[FRAME_W-1];
                sh  <= sh << 1;
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assign last = act && (cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (cnt < CNT_W'(FRAME_W))); // R2
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !load) |=> !ser); // R4
endmodule

// File: rtl/lreq_tx.sv
module lreq_tx
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_accel,
    output logic              busy,
    output logic              done,
    input  logic [1:0]        ctl,
    input  logic              hcrc_err,
    input  logic              cyc_start,
    output logic              lreq,
    output logic              ack_start,
    output logic              ack_cancel
);
    localparam int FRAME_W = 5 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    st_t                st, nxt;
    kind_t              kind_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               accel_q;
    logic [1:0]         ctl_q;
    logic               cs_seen, crc_bad;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;
    logic               arb, go, load, abort, last, finish, grant;

    lreq_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .kind  (kind_q),
        .addr  (addr_q),
        .data  (data_q),
        .accel (accel_q),
        .frame (frame),
        .len   (len)
    );

    lreq_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .abort (abort),
        .frame (frame),
        .len   (len),
        .ser   (lreq),
        .last  (last)
    );

    assign arb   = (kind_q == K_FAIR) || (kind_q == K_PRI);
    assign grant = (st == S_WGRANT) && (ctl == CTL_GRANT);

    always_comb begin
        unique case (kind_q)
            K_FAIR, K_PRI: go = (ctl == CTL_IDLE) && (ctl_q == CTL_IDLE);
            K_IMM:         go = (ctl == CTL_RCV);
            K_ISO:         go = cs_seen;
            default:       go = 1'b1;
        endcase
    end

    assign load   = (st == S_PEND) && go;
    assign abort  = (st == S_SHIFT) && arb && (ctl == CTL_RCV);
    assign finish = ((st == S_SHIFT) && !abort && last && (kind_q != K_IMM)) || grant;

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (cmd_valid) nxt = S_PEND;
            S_PEND:   if (go) nxt = S_SHIFT;
            S_SHIFT: begin
                if (abort)      nxt = S_PEND;
                else if (last)  nxt = (kind_q == K_IMM) ? S_WGRANT : S_IDLE;
            end
            S_WGRANT: if (ctl == CTL_GRANT) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= K_READ;
            addr_q     <= '0;
            data_q     <= '0;
            accel_q    <= 1'b0;
            ctl_q      <= CTL_IDLE;
            cs_seen    <= 1'b0;
            crc_bad    <= 1'b0;
            done       <= 1'b0;
            ack_start  <= 1'b0;
            ack_cancel <= 1'b0;
        end else begin
            ctl_q      <= ctl;
            done       <= finish;
            ack_start  <= grant && !(crc_bad || hcrc_err);
            ack_cancel <= grant &&  (crc_bad || hcrc_err);
            if (st == S_IDLE && cmd_valid) begin
                kind_q  <= kind_t'(cmd_kind);
                addr_q  <= cmd_addr;
                data_q  <= cmd_data;
                accel_q <= cmd_accel;
                crc_bad <= 1'b0;
            end else if (st != S_IDLE && hcrc_err) begin
                crc_bad <= 1'b1;
            end
            if (cyc_start)                  cs_seen <= 1'b1;
            else if (load && kind_q == K_ISO) cs_seen <= 1'b0;
        end
    end

    assign busy = (st != S_IDLE);

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lreq); // R4
    AST_ARB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (arb && st == S_SHIFT && $past(st) == S_PEND) |-> ($past(ctl) == CTL_IDLE)); // R5
    AST_RCV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT && arb && ctl == CTL_RCV) |=> (!lreq && busy)); // R6
    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_start && ack_cancel)); // R8
    AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !$past(lreq))); // R10
endmodule

// File: tb/sim_lreq_tx.sv
module sim_lreq_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_kind = '0;
    logic [3:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       cmd_accel = 1'b0;
    logic [1:0] ctl = 2'b00;
    logic       hcrc_err = 1'b0;
    logic       cyc_start = 1'b0;
    logic       busy, done, lreq, ack_start, ack_cancel;

    int         n_chk = 0;
    int         n_bad = 0;
    logic       mon_en = 1'b1;
    logic [16:0] exp_bits[$];
    int         exp_len[$];

    always #4 clk = ~clk;

    lreq_tx u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_accel(cmd_accel),
        .busy(busy), .done(done), .ctl(ctl), .hcrc_err(hcrc_err),
        .cyc_start(cyc_start), .lreq(lreq), .ack_start(ack_start),
        .ack_cancel(ack_cancel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_frame(input logic [16:0] bits, input int len);
        exp_bits.push_back(bits);
        exp_len.push_back(len);
    endtask

    task automatic issue(input logic [2:0] k, input logic [3:0] a, input logic [7:0] d, input logic x);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_data = d; cmd_accel = x;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (done !== 1'b1 && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(req, {31'd0, done}, 32'd1);
        check(req, {31'd0, busy}, 32'd0);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (mon_en && lreq === 1'b1) begin
                if (exp_len.size() == 0) begin
                    check("R10", 32'hBAD, 32'h0);
                end else begin
                    logic [16:0] b;
                    int          l;
                    b = exp_bits.pop_front();
                    l = exp_len.pop_front();
                    check("R1-frame", {31'd0, lreq}, {31'd0, b[16]});
                    for (int i = 1; i < l; i++) begin
                        @(negedge clk);
                        check("R4 bit", {31'd0, lreq}, {31'd0, b[16-i]});
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check("R10 reset busy", {31'd0, busy}, 32'd0);
        check("R4 reset lreq", {31'd0, lreq}, 32'd0);
        check("R10 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        // R1 read, address 1010
        expect_frame({1'b1, 3'b100, 4'hA, 1'b0, 8'h00}, 9);
        issue(3'd0, 4'hA, 8'h00, 1'b0);
        check("R10 busy after accept", {31'd0, busy}, 32'd1);
        wait_done("R1");

        // R2 write, with an ignored command while busy (R10)
        expect_frame({1'b1, 3'b101, 4'h3, 8'hC5, 1'b0}, 17);
        issue(3'd1, 4'h3, 8'hC5, 1'b0);
        issue(3'd0, 4'hF, 8'h00, 1'b0);
        wait_done("R2");
        repeat (4) @(negedge clk);
        check("R10 ignored cmd", {31'd0, busy}, 32'd0);
        check("R10 no extra frame", exp_len.size(), 32'd0);

        // R3 acceleration on and off
        expect_frame({1'b1, 3'b110, 1'b1, 1'b0, 11'd0}, 6);
        issue(3'd2, 4'h0, 8'h00, 1'b1);
        wait_done("R3 on");
        expect_frame({1'b1, 3'b110, 1'b0, 1'b0, 11'd0}, 6);
        issue(3'd2, 4'h0, 8'h00, 1'b0);
        wait_done("R3 off");

        // R5 priority request held while ctl is status
        ctl = 2'b01;
        issue(3'd4, 4'h0, 8'h00, 1'b0);
        repeat (5) @(negedge clk);
        check("R5 held", {30'd0, busy, lreq}, 32'd2);
        expect_frame({1'b1, 3'b010, 1'b0, 12'd0}, 5);
        ctl = 2'b00;
        @(negedge clk);
        check("R5 gap", {31'd0, lreq}, 32'd0);
        @(negedge clk);
        check("R5 start", {31'd0, lreq}, 32'd1);
        wait_done("R5");

        // R6 receive during a fair frame, then full reissue
        mon_en = 1'b0;
        issue(3'd3, 4'h0, 8'h00, 1'b0);
        while (lreq !== 1'b1) @(negedge clk);
        @(negedge clk);
        ctl = 2'b10;
        @(negedge clk);
        check("R6 drop", {30'd0, busy, lreq}, 32'd2);
        repeat (3) @(negedge clk);
        check("R6 quiet", {31'd0, lreq}, 32'd0);
        mon_en = 1'b1;
        expect_frame({1'b1, 3'b011, 1'b0, 12'd0}, 5);
        ctl = 2'b00;
        wait_done("R6 reissue");
        check("R6 frame consumed", exp_len.size(), 32'd0);

        // R7/R8 immediate request, good header
        issue(3'd5, 4'h0, 8'h00, 1'b0);
        repeat (4) @(negedge clk);
        check("R7 wait rcv", {30'd0, busy, lreq}, 32'd2);
        expect_frame({1'b1, 3'b000, 1'b0, 12'd0}, 5);
        ctl = 2'b10;
        repeat (10) @(negedge clk);
        check("R8 wait grant", {30'd0, busy, done}, 32'd2);
        ctl = 2'b11;
        @(negedge clk);
        check("R8 ack", {29'd0, ack_start, ack_cancel, done}, 32'd5);
        ctl = 2'b00;
        @(negedge clk);
        check("R8 pulse", {30'd0, ack_start, busy}, 32'd0);

        // R8 immediate request, bad header CRC
        ctl = 2'b10;
        expect_frame({1'b1, 3'b000, 1'b0, 12'd0}, 5);
        issue(3'd5, 4'h0, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        hcrc_err = 1'b1;
        @(negedge clk);
        hcrc_err = 1'b0;
        repeat (8) @(negedge clk);
        ctl = 2'b11;
        @(negedge clk);
        check("R8 cancel", {29'd0, ack_start, ack_cancel, done}, 32'd3);
        ctl = 2'b00;

        // R9 isochronous waits for cycle start
        issue(3'd6, 4'h0, 8'h00, 1'b0);
        repeat (4) @(negedge clk);
        check("R9 held", {30'd0, busy, lreq}, 32'd2);
        expect_frame({1'b1, 3'b001, 1'b0, 12'd0}, 5);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        wait_done("R9");

        // R4 fair code after a clean idle gap
        expect_frame({1'b1, 3'b011, 1'b0, 12'd0}, 5);
        issue(3'd3, 4'h0, 8'h00, 1'b0);
        wait_done("R4 fair");
        repeat (3) @(negedge clk);
        check("R4 all frames", exp_len.size(), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule